// File: doc/BRIEF.md
# Ticket Lock Arbiter

This block is a hardware lock that several requesters share, and it hands the lock out in strict order of arrival. It keeps two counters. The dispense counter gives the next place in line, and the owner counter names the ticket that holds the lock now. A requester that asks for the lock is given the current dispense value as its ticket, and the dispense counter steps forward in the same clock edge, so taking a ticket is atomic. A requester holds the lock while the owner counter equals its ticket. The holder lets go with a release strobe, which advances the owner counter and passes the lock to the next ticket in line.

Each requester sees its own ticket, its own grant and its distance from the head of the queue. The distance is the ticket minus the owner counter, and software can use it to choose how long to back off. A release from a requester that does not hold the lock does not change the lock state and raises an error pulse. Both counters wrap modulo 2^W. W is derived from the requester count, and because each requester holds at most one ticket, a wrapped ticket never aliases one that is still live.

Top module: `ticket_lock`

## Requirements
- R1: After reset no grant is asserted, the error output is low, both counters are zero, and the first ticket handed out is 0.
- R2: An acquire strobe from a requester that holds no ticket loads that requester's ticket output with the current dispense value after the next clock edge. The dispense counter then advances by one.
- R3: When several idle requesters strobe acquire in the same cycle, they receive consecutive tickets in ascending requester-index order, and the lowest index gets the lowest ticket.
- R4: A requester's grant is high exactly when it holds a ticket equal to the owner counter. At most one grant is high at any time.
- R5: A release strobe from the grant holder advances the owner counter by one after the clock edge. That requester's ticket is dropped, and the holder of the next ticket is granted from that edge on.
- R6: Grants are issued in the order the tickets were handed out (FIFO).
- R7: For a requester holding a ticket, the wait output equals (ticket − owner) modulo 2^W, so it is 0 for the holder. For a requester without a ticket, the wait output is 0.
- R8: A release strobe from a requester that is not granted leaves the owner counter unchanged. It sets the error output high for exactly the cycle after the strobe.
- R9: An acquire strobe from a requester that already holds a ticket is ignored, and its ticket is unchanged. This includes a strobe given in the same cycle as that requester's release.
- R10: Both counters wrap modulo 2^W with W = max(1, ceil(log2 N)), and service order stays FIFO across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acq_i | input | N_REQ | Per-requester acquire strobe |
| rel_i | input | N_REQ | Per-requester release strobe |
| grant_o | output | N_REQ | Per-requester lock grant |
| ticket_o | output | N_REQ*W | Per-requester ticket; lane i is bits [i*W +: W] |
| wait_o | output | N_REQ*W | Per-requester queue distance, ticket minus owner |
| rel_err_o | output | 1 | Pulses one cycle after a release from a non-holder |

## Verification
The hardest case to reach is wraparound while the queue is full. The dispense counter has to pass 2^W while older tickets are still waiting, so that a small ticket number is served after larger ones. The stimulus first fills the queue with simultaneous acquires. It then keeps re-acquiring as each holder releases, for hundreds of cycles, mixing in stray releases and acquire strobes from requesters that are already queued. A scoreboard records the expected grant order at dispense time and compares it with each new grant as it appears.

// File: rtl/ticket_lock_pkg.sv
package ticket_lock_pkg;
  function automatic int cnt_width(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tl_dispenser.sv
module tl_dispenser #(
  parameter int N_REQ = 4,
  parameter int CNT_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_REQ-1:0]       take_i,
  output logic [N_REQ*CNT_W-1:0] lane_tkt_o
);
  logic [CNT_W-1:0] next_q, cnt;

  // tickets for same-cycle takes are assigned in index order
  always_comb begin
    cnt = '0;
    lane_tkt_o = '0;
    for (int i = 0; i < N_REQ; i++) begin
      lane_tkt_o[i*CNT_W +: CNT_W] = next_q + cnt;
      cnt = cnt + CNT_W'(take_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) next_q <= '0;
    else         next_q <= next_q + cnt;
  end
endmodule

// File: rtl/tl_slot.sv
module tl_slot #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [CNT_W-1:0] new_tkt_i,
  input  logic             drop_i,
  input  logic [CNT_W-1:0] serving_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] tkt_o,
  output logic             grant_o,
  output logic [CNT_W-1:0] wait_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      tkt_o  <= '0;
    end else if (take_i) begin
      busy_o <= 1'b1;
      tkt_o  <= new_tkt_i;
    end else if (drop_i) begin
      busy_o <= 1'b0;
    end
  end

  assign grant_o = busy_o && (tkt_o == serving_i);
  assign wait_o  = busy_o ? (tkt_o - serving_i) : '0;
endmodule

// File: rtl/ticket_lock.sv
module ticket_lock #(
  parameter int N_REQ = 4,
  localparam int CNT_W = ticket_lock_pkg::cnt_width(N_REQ)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_REQ-1:0]       acq_i,
  input  logic [N_REQ-1:0]       rel_i,
  output logic [N_REQ-1:0]       grant_o,
  output logic [N_REQ*CNT_W-1:0] ticket_o,
  output logic [N_REQ*CNT_W-1:0] wait_o,
  output logic                   rel_err_o
);
  logic [N_REQ-1:0]       busy, take, drop;
  logic [N_REQ*CNT_W-1:0] lane_tkt;
  logic [CNT_W-1:0]       serving_q;
  logic                   rel_ok;

  assign take   = acq_i & ~busy;
  assign drop   = rel_i & grant_o;
  assign rel_ok = |drop;

  tl_dispenser #(.N_REQ(N_REQ), .CNT_W(CNT_W)) u_disp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .lane_tkt_o (lane_tkt)
  );

  for (genvar i = 0; i < N_REQ; i++) begin : g_slot
    tl_slot #(.CNT_W(CNT_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .take_i    (take[i]),
      .new_tkt_i (lane_tkt[i*CNT_W +: CNT_W]),
      .drop_i    (drop[i]),
      .serving_i (serving_q),
      .busy_o    (busy[i]),
      .tkt_o     (ticket_o[i*CNT_W +: CNT_W]),
      .grant_o   (grant_o[i]),
      .wait_o    (wait_o[i*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serving_q <= '0;
      rel_err_o <= 1'b0;
    end else begin
      if (rel_ok) serving_q <= serving_q + 1'b1;
      rel_err_o <= |(rel_i & ~grant_o);
    end
  end
endmodule

// File: rtl/ticket_lock_chk.sv
module ticket_lock_chk #(
  parameter int N_REQ = 4,
  parameter int CNT_W = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_REQ-1:0]       acq_i,
  input logic [N_REQ-1:0]       rel_i,
  input logic [N_REQ-1:0]       grant_o,
  input logic [N_REQ*CNT_W-1:0] ticket_o,
  input logic [N_REQ*CNT_W-1:0] wait_o,
  input logic                   rel_err_o,
  input logic [CNT_W-1:0]       serving_q
);
  // R4
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  // R8
  bad_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(rel_i & ~grant_o) |=> rel_err_o);
  // R8
  owner_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(rel_i & grant_o)) |=> $stable(serving_q));
  // R5
  owner_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(rel_i & grant_o) |=> serving_q == $past(serving_q) + 1'b1);

  for (genvar i = 0; i < N_REQ; i++) begin : g_lane
    // R7
    holder_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[i] |-> wait_o[i*CNT_W +: CNT_W] == '0);
    // R9
    held_tkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[i] && acq_i[i] && !rel_i[i]) |=> $stable(ticket_o[i*CNT_W +: CNT_W]));
  end
endmodule

bind ticket_lock ticket_lock_chk #(.N_REQ(N_REQ), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/ticket_lock_tb.sv
module ticket_lock_tb;
  localparam int N = 4;
  localparam int W = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   acq = '0, rel = '0;
  logic [N-1:0]   grant;
  logic [N*W-1:0] ticket, waitv;
  logic           rel_err;

  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  logic [N-1:0] prev_grant = '0;

  logic [W-1:0] m_next, m_serv;
  logic [W-1:0] m_tkt [N];
  logic [N-1:0] m_busy;
  logic         m_err;

  always #2 clk = ~clk;

  ticket_lock #(.N_REQ(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acq_i(acq), .rel_i(rel),
    .grant_o(grant), .ticket_o(ticket), .wait_o(waitv), .rel_err_o(rel_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_grant();
    logic [N-1:0] g;
    for (int i = 0; i < N; i++) g[i] = m_busy[i] && (m_tkt[i] == m_serv);
    return g;
  endfunction

  // monitor: each newly raised grant must match the oldest queued ticket holder (R6)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (grant[i] && !prev_grant[i]) begin
          if (exp_q.size() == 0) chk("R6 grant order (empty queue)", i, -1);
          else chk("R6 grant order", i, exp_q.pop_front());
        end
      end
    end
    prev_grant = grant;
  end

  task automatic check_all();
    chk("R8 rel_err", int'(rel_err), int'(m_err));
    for (int i = 0; i < N; i++) begin
      chk("R4 grant", int'(grant[i]), int'(m_grant() >> i) & 1);
      if (m_busy[i]) chk("R2 ticket", int'(ticket[i*W +: W]), int'(m_tkt[i]));
      chk("R7 wait", int'(waitv[i*W +: W]),
          m_busy[i] ? int'(W'(m_tkt[i] - m_serv)) : 0);
    end
  endtask

  // driver: apply strobes for one edge, update the model, push expected grants
  task automatic cyc(input logic [N-1:0] a, input logic [N-1:0] r);
    logic [N-1:0] g, take;
    g = m_grant();
    take = a & ~m_busy;
    m_err = |(r & ~g);
    for (int i = 0; i < N; i++) begin
      if (take[i]) begin
        m_tkt[i] = m_next;
        m_busy[i] = 1'b1;
        m_next = m_next + 1'b1;
        exp_q.push_back(i);
      end
    end
    if (|(r & g)) begin
      m_busy = m_busy & ~(r & g);
      m_serv = m_serv + 1'b1;
    end
    acq = a; rel = r;
    @(negedge clk);
    acq = '0; rel = '0;
    check_all();
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    m_next = '0; m_serv = '0; m_busy = '0; m_err = 1'b0;
    for (int i = 0; i < N; i++) m_tkt[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 grant after reset", int'(grant), 0);
    chk("R1 rel_err after reset", int'(rel_err), 0);
    // R1 R2 first acquire gets ticket 0 and the lock
    cyc(4'b0001, '0);
    chk("R1 first ticket", int'(ticket[1:0]), 0);
    chk("R2 idle acquire granted", int'(grant[0]), 1);
    // R3 simultaneous acquires in index order
    cyc(4'b1110, '0);
    chk("R3 lane1 ticket", int'(ticket[3:2]), 1);
    chk("R3 lane3 ticket", int'(ticket[7:6]), 3);
    chk("R7 lane3 wait", int'(waitv[7:6]), 3);
    // R9 acquire while queued is ignored
    cyc(4'b0010, '0);
    chk("R9 lane1 ticket kept", int'(ticket[3:2]), 1);
    // R8 release from non-holder
    cyc('0, 4'b0100);
    chk("R8 err pulse", int'(rel_err), 1);
    chk("R8 holder kept", int'(grant), 1);
    cyc('0, '0);
    chk("R8 err one cycle", int'(rel_err), 0);
    // R5 valid release passes the lock; R9 same-cycle re-acquire ignored
    cyc(4'b0001, 4'b0001);
    chk("R5 next holder", int'(grant), 2);
    chk("R9 lane0 dropped", int'(waitv[1:0]), 0);
    // R10 wrap: lane0 re-acquires, gets ticket 4 mod 4 = 0
    cyc(4'b0001, '0);
    chk("R10 wrapped ticket", int'(ticket[1:0]), 0);
    chk("R10 wrapped wait", int'(waitv[1:0]), 3);
    // long mixed run crossing many wraps (R6 R10)
    lfsr = 8'h5a;
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] r;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      r = (k % 2 == 0) ? m_grant() : '0;
      if (k % 7 == 3) r = r | (~m_grant() & lfsr[7:4]);
      cyc(lfsr[3:0], r);
    end
    repeat (8) cyc('0, m_grant());
    chk("R6 queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule